// File: doc/BRIEF.md
# Cascaded Two-Controller Interrupt Acknowledge Unit

This block joins two eight-line request cores into one sixteen-line interrupt system. Lines 0 to 7 belong to the primary core and lines 8 to 15 to the secondary core. The secondary core's "something pending" state is fed into primary line 2 as an edge request. A single CPU interrupt pin reports whether the primary core holds any request. The CPU collects the interrupt through an acknowledge handshake. That handshake resolves the winner on the primary core, goes on to the secondary core when the winner is line 2, clears the acknowledged edge request, and returns an 8-bit vector.

Each core has a programmable vector base and a trigger-select register that picks edge or level sensing per line. Some trigger bits are hard-wired to edge mode. No other register programming exists. Priority is fixed, and a lower line number wins inside each core. Requests are not masked, and no in-service state is kept: every acknowledge acts as an automatic end of interrupt.

The acknowledge output is a valid/ready stream of one-entry depth. A request on `ack_req` is taken only while `ack_valid` is low. A request raised while a vector is waiting is dropped and changes nothing. `ack_valid` and `ack_vector` then hold until a cycle with `ack_ready` high.

Top module: `cascade_ack_unit`

## Requirements
- R1: Line n for n below 8 raises a request in the primary core. Line n for n of 8 or more raises request n-8 in the secondary core. The vector is primary base plus n, or secondary base plus (n-8).
- R2: Within a core, the lowest pending line number wins. The overall order is primary 0, primary 1, secondary 8..15 (through primary line 2), then primary 3..7.
- R3: While the secondary core holds any request, primary line 2 is pending, so `cpu_int` is high. Both take effect on the same clock edge that latches the secondary request.
- R4: An acknowledge taken while the primary core has no request returns primary base + 7.
- R5: An acknowledge that picks primary line 2 while the secondary core is empty returns secondary base + 7.
- R6: Base writes keep bits 7:3 and force bits 2:0 to zero. `cfg_addr` codes: 0 primary base, 1 secondary base, 2 primary trigger, 3 secondary trigger.
- R7: Trigger writes are masked with 0xF8 (primary) and 0xDE (secondary). A bit equal to 1 selects level sensing. Lines whose mask bit is 0 always stay edge-sensed.
- R8: An edge line latches on a 0-to-1 input change, and its acknowledge clears it. An input that stays high does not request again. A level line follows its input and is not cleared by an acknowledge.
- R9: `cpu_int` is high exactly when the primary core has a request. It is updated one clock edge after an input change and on the same edge that takes an acknowledge.
- R10: An `ack_req` taken with `ack_valid` low raises `ack_valid` on the next edge. The vector holds stable until a cycle with `ack_ready` high. An `ack_req` during `ack_valid` is ignored.
- R11: After reset, `cpu_int` and `ack_valid` are low, both bases are 0 and all lines are edge-sensed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines, index 0..15 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| ack_req | input | 1 | CPU acknowledge request |
| ack_ready | input | 1 | CPU has taken the vector |
| ack_valid | output | 1 | Vector is waiting |
| ack_vector | output | 8 | Acknowledged vector number |
| cpu_int | output | 1 | Interrupt request to the CPU |

## Verification
The first sweep pulses every one of the sixteen lines alone. It separates the routing of the two cores, and it separates external primary line 2 (which yields the secondary spurious vector) from the rest. Next, every pair of lines other than line 2 is pulsed together. The order of two acknowledges is then compared with the arithmetic priority rank, which shows that secondary requests sit between primary lines 1 and 3. Level runs with all-ones trigger writes separate the lines that may be level-sensed from the lines forced to edge. They also show that primary line 2 stays latched after a secondary level request drops. A stall with repeated requests shows that nothing is lost or taken twice.

// File: rtl/cascade_pic_pkg.sv
package cascade_pic_pkg;
  localparam int CORE_LINES   = 8;
  localparam int CORE_IDX_W   = $clog2(CORE_LINES);
  localparam int VECTOR_W     = 8;
  localparam int CASCADE_LINE = 2;

  typedef enum logic [1:0] {
    CFG_PRI_BASE = 2'd0,
    CFG_SEC_BASE = 2'd1,
    CFG_PRI_TRIG = 2'd2,
    CFG_SEC_TRIG = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: scan downwards so the last hit is the smallest
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_req_core.sv
module pic_req_core #(
  parameter int               LINES     = 8,
  parameter logic [LINES-1:0] TRIG_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  input  logic             trig_wr,
  input  logic [LINES-1:0] trig_wdata,
  input  logic [LINES-1:0] ack_clr,
  input  logic [LINES-1:0] cascade_set,
  output logic [LINES-1:0] req_q,
  output logic [LINES-1:0] req_d
);
  logic [LINES-1:0] trig_q;
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      if (trig_wr) trig_q <= trig_wdata & TRIG_MASK;
      prev_q <= lines_in;
      req_q  <= req_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic rise;
    assign rise = lines_in[g] & ~prev_q[g];
    always_comb begin
      if (trig_q[g]) req_d[g] = lines_in[g];
      else           req_d[g] = (req_q[g] & ~ack_clr[g]) | rise | cascade_set[g];
    end
  end
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit
  import cascade_pic_pkg::*;
#(
  parameter int LINES      = CORE_LINES,
  parameter int VEC_W      = VECTOR_W,
  parameter int CASC_LINE  = CASCADE_LINE,
  parameter logic [LINES-1:0] PRI_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SEC_TRIG_MASK = 8'hDE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*LINES-1:0]   irq_in,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [VEC_W-1:0]     cfg_wdata,
  input  logic                 ack_req,
  input  logic                 ack_ready,
  output logic                 ack_valid,
  output logic [VEC_W-1:0]     ack_vector,
  output logic                 cpu_int
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);

  cfg_sel_e cfg_sel;
  assign cfg_sel = cfg_sel_e'(cfg_addr);

  logic [VEC_W-1:0] p_base, s_base;
  logic [LINES-1:0] p_req, p_req_d, s_req, s_req_d;
  logic [LINES-1:0] p_clr, s_clr, p_casc;
  logic             p_found, s_found, accept, go_sec;
  logic [IDX_W-1:0] p_idx, s_idx;
  logic [VEC_W-1:0] vec_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_base <= '0;
      s_base <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_PRI_BASE) p_base <= {cfg_wdata[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
      if (cfg_sel == CFG_SEC_BASE) s_base <= {cfg_wdata[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
    end
  end

  pic_prio_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_pick_pri (
    .req(p_req), .found(p_found), .idx(p_idx));
  pic_prio_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_pick_sec (
    .req(s_req), .found(s_found), .idx(s_idx));

  assign accept = ack_req & ~ack_valid;
  assign go_sec = accept & p_found & (p_idx == IDX_W'(CASC_LINE));
  assign p_clr  = (accept & p_found) ? (LINES'(1) << p_idx) : '0;
  assign s_clr  = (go_sec & s_found) ? (LINES'(1) << s_idx) : '0;

  // secondary pending after this edge pulses primary cascade line
  always_comb begin
    p_casc            = '0;
    p_casc[CASC_LINE] = |s_req_d;
  end

  pic_req_core #(.LINES(LINES), .TRIG_MASK(SEC_TRIG_MASK)) u_core_sec (
    .clk(clk), .rst_n(rst_n),
    .lines_in(irq_in[2*LINES-1:LINES]),
    .trig_wr(cfg_we && cfg_sel == CFG_SEC_TRIG),
    .trig_wdata(cfg_wdata[LINES-1:0]),
    .ack_clr(s_clr), .cascade_set('0),
    .req_q(s_req), .req_d(s_req_d));

  pic_req_core #(.LINES(LINES), .TRIG_MASK(PRI_TRIG_MASK)) u_core_pri (
    .clk(clk), .rst_n(rst_n),
    .lines_in(irq_in[LINES-1:0]),
    .trig_wr(cfg_we && cfg_sel == CFG_PRI_TRIG),
    .trig_wdata(cfg_wdata[LINES-1:0]),
    .ack_clr(p_clr), .cascade_set(p_casc),
    .req_q(p_req), .req_d(p_req_d));

  always_comb begin
    if (!p_found)                          vec_d = {p_base[VEC_W-1:IDX_W], SPUR_IDX};
    else if (p_idx != IDX_W'(CASC_LINE))   vec_d = {p_base[VEC_W-1:IDX_W], p_idx};
    else if (s_found)                      vec_d = {s_base[VEC_W-1:IDX_W], s_idx};
    else                                   vec_d = {s_base[VEC_W-1:IDX_W], SPUR_IDX};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else if (accept) begin
      ack_valid  <= 1'b1;
      ack_vector <= vec_d;
    end else if (ack_ready) begin
      ack_valid  <= 1'b0;
    end
  end

  assign cpu_int = p_found;
endmodule

// File: rtl/cascade_ack_checker.sv
module cascade_ack_checker #(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_req,
  input logic             ack_ready,
  input logic             ack_valid,
  input logic [VEC_W-1:0] ack_vector,
  input logic             cpu_int,
  input logic [VEC_W-1:0] p_base,
  input logic [LINES-1:0] s_req
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !ack_valid |=> ack_valid);                               // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid && $stable(ack_vector));      // R10
  AST_SPURIOUS_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !ack_valid && !cpu_int |=>
      ack_vector == {$past(p_base[VEC_W-1:IDX_W]), {IDX_W{1'b1}}});     // R4
  AST_SEC_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_req) |-> cpu_int);                                              // R3
endmodule

bind cascade_ack_unit cascade_ack_checker #(.LINES(LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_ready(ack_ready),
  .ack_valid(ack_valid), .ack_vector(ack_vector), .cpu_int(cpu_int),
  .p_base(p_base), .s_req(s_req));

// File: tb/test_cascade_ack_unit.sv
module test_cascade_ack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ack_req = 1'b0;
  logic        ack_ready = 1'b0;
  logic        ack_valid;
  logic [7:0]  ack_vector;
  logic        cpu_int;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pb = 0;
  int sb = 0;

  always #2 clk = ~clk;

  cascade_ack_unit i_cascade_ack_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack_req(ack_req),
    .ack_ready(ack_ready), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .cpu_int(cpu_int));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(output int v);
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    check("R10 valid", int'(ack_valid), 1);
    v = int'(ack_vector);
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    check("R10 released", int'(ack_valid), 0);
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    irq_in = m;
    @(negedge clk);
    irq_in = '0;
  endtask

  function automatic int rank(input int l);
    if (l < 2) return l;
    if (l >= 8) return l - 6;
    return l + 7;
  endfunction

  function automatic int vec_of(input int l);
    if (l < 8) return pb + l;
    return sb + (l - 8);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 cpu_int", int'(cpu_int), 0);
    check("R11 ack_valid", int'(ack_valid), 0);
    do_ack(v);
    check("R11 R4 zero base spurious", v, 8'h07);

    // R6 bases drop low bits
    cfg_write(2'd0, 8'h4D); pb = 8'h48;
    cfg_write(2'd1, 8'h93); sb = 8'h90;
    do_ack(v);
    check("R6 R4 primary base masked", v, pb + 7);

    // R1 R5 R8 single-line sweep
    for (int l = 0; l < 16; l++) begin
      pulse(16'(1) << l);
      check("R9 R3 cpu_int raised", int'(cpu_int), 1);
      do_ack(v);
      check("R1 R5 vector", v, (l == 2) ? sb + 7 : vec_of(l));
      check("R8 edge cleared", int'(cpu_int), 0);
      do_ack(v);
      check("R4 spurious after", v, pb + 7);
    end

    // R2 pair sweep, line 2 left out
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a != 2 && b != 2) begin
          int first, second;
          first  = (rank(a) < rank(b)) ? a : b;
          second = (first == a) ? b : a;
          pulse((16'(1) << a) | (16'(1) << b));
          do_ack(v);
          check("R2 first", v, vec_of(first));
          check("R2 still pending", int'(cpu_int), 1);
          do_ack(v);
          check("R2 second", v, vec_of(second));
          check("R9 empty", int'(cpu_int), 0);
        end
      end
    end

    // R10 stall with extra requests ignored
    pulse(16'h0003);
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    check("R10 first vector", int'(ack_vector), pb + 0);
    repeat (3) @(negedge clk);
    check("R10 held valid", int'(ack_valid), 1);
    check("R10 held vector", int'(ack_vector), pb + 0);
    ack_req = 1'b0;
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    check("R10 line 1 not consumed", int'(cpu_int), 1);
    do_ack(v);
    check("R10 second vector", v, pb + 1);
    check("R10 drained", int'(cpu_int), 0);

    // R7 R8 primary level sensing
    cfg_write(2'd2, 8'hFF);
    @(negedge clk); irq_in = 16'h0008;
    @(negedge clk);
    check("R9 level raised", int'(cpu_int), 1);
    do_ack(v);
    check("R8 level vector", v, pb + 3);
    check("R8 level kept", int'(cpu_int), 1);
    do_ack(v);
    check("R8 level again", v, pb + 3);
    irq_in = '0;
    @(negedge clk);
    check("R8 level follows input", int'(cpu_int), 0);
    irq_in = 16'h0001;
    do_ack(v);
    check("R7 primary line 0 edge", v, pb + 0);
    check("R7 R8 held high no retrigger", int'(cpu_int), 0);
    irq_in = '0;

    // R7 secondary level sensing and sticky cascade line
    cfg_write(2'd3, 8'hFF);
    @(negedge clk); irq_in = 16'h0200;
    @(negedge clk);
    do_ack(v);
    check("R7 secondary level vector", v, sb + 1);
    check("R8 secondary level kept", int'(cpu_int), 1);
    irq_in = '0;
    @(negedge clk);
    check("R5 cascade line latched", int'(cpu_int), 1);
    do_ack(v);
    check("R5 secondary spurious", v, sb + 7);
    irq_in = 16'h2000;
    do_ack(v);
    check("R7 secondary line 5 edge", v, sb + 5);
    check("R7 held high no retrigger", int'(cpu_int), 0);
    irq_in = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule